// File: doc/BRIEF.md
# Circular Command FIFO Peek Unit

This block holds a shared command RAM in which each of up to eight channels owns a circular FIFO region. The region of each channel is set by a lower bound and an upper bound. The live read and write pointers of every channel come in as inputs. Ordinary push and pop traffic changes only those pointers, which this block never modifies. A debug agent uses a control word to select a channel and a RAM address. The agent then reads the stored entry one clock later without consuming it. The agent can also read the pointers of the selected channel packed into one word, and a flag that shows whether that channel's FIFO is empty.

A walk mode drains nothing but lists the whole live content of the selected channel. It starts at the read pointer, emits one entry per clock with its address, and wraps from the upper bound back to the lower bound. It stops just before the write pointer. The walk is run by a three-state machine:
- `WK_IDLE` waits for an accepted start.
- `WK_STEP` reads one entry per cycle.
- `WK_LAST` presents the final entry together with a done strobe.

The transitions are:
- *start* takes `WK_IDLE` to `WK_STEP`, on a start request while peeking is enabled and the FIFO is not empty.
- *advance* keeps the machine in `WK_STEP` while the next pointer differs from the captured write pointer.
- *finish* takes `WK_STEP` to `WK_LAST` when the next pointer equals the captured write pointer.
- *retire* takes `WK_LAST` back to `WK_IDLE` unconditionally.

Top module: `cfp_peek`

## Requirements
- R1: After reset, `peek_data`, `walk_valid` and `walk_done` are zero, and `ptr_word` shows the pointers of channel 0.
- R2: Peek request. Bit 31 of `ctrl_wdata` is the enable, bits 18:16 are the channel and bits 8:0 are the RAM address. When peeking is disabled, a control write with the enable set makes `peek_data` equal to the RAM word at that address from the next clock on. The value then holds until the next accepted control write.
- R3: An accepted control write with bit 31 clear, such as an all-zero word, disables peeking. `peek_data` reads zero from the next clock on.
- R4: A control write with the enable set while peeking is already enabled is ignored. Channel, address and `peek_data` keep their values, so software must write zero before each new peek address.
- R5: `ptr_word` carries the read pointer of the selected channel in bits 8:0 and its write pointer in bits 24:16. All other bits are zero.
- R6: In each 32-bit slice of `setup_words`, bits 8:0 hold the lower bound of the region and bits 24:16 hold the upper bound.
- R7: `cf_empty` is high exactly when the read and write pointers of the selected channel are equal.
- R8: `walk_go` sampled at clock edge k, while idle, enabled and non-empty, starts a walk. The first entry appears on `walk_addr`/`walk_data` with `walk_valid` after edge k+1, and it is the entry at the read pointer.
- R9: Consecutive walk entries follow the pointer step. After the upper bound the next address is the lower bound; otherwise the address is incremented. The walk emits one entry for each slot from the read pointer up to, but not including, the write pointer, in consecutive cycles.
- R10: `walk_done` is high in exactly the cycle that shows the last walk entry.
- R11: `walk_go` starts nothing when the selected FIFO is empty or when peeking is disabled.
- R12: Control writes made while a walk is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_we | input | 1 | Command RAM write strobe |
| ram_waddr | input | AW | Command RAM write address |
| ram_wdata | input | DW | Command RAM write data |
| setup_words | input | NUM_CH*32 | Per-channel region bounds, 32 bits per channel |
| rd_ptrs | input | NUM_CH*AW | Live read pointer of each channel |
| wr_ptrs | input | NUM_CH*AW | Live write pointer of each channel |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: enable, channel, address |
| walk_go | input | 1 | Request to walk the selected channel |
| peek_data | output | DW | Entry read by the last peek, zero when disabled |
| ptr_word | output | 32 | Packed read and write pointers of the selected channel |
| cf_empty | output | 1 | Selected channel FIFO is empty |
| walk_valid | output | 1 | Walk entry valid |
| walk_addr | output | AW | RAM address of the walk entry |
| walk_data | output | DW | Walk entry contents |
| walk_done | output | 1 | Marks the last walk entry |

## Verification
A wrong state in the walk machine shows at the ports within one or two clocks. If it advances too far or stops too early, the address sequence breaks the wrap order, or the number of entries differs from the slot count between the two pointers. If it retires late, `walk_done` drifts away from the last valid entry. A corrupted control register shows up on the next clock as a wrong `peek_data` or `ptr_word`, or as a peek that fails to disable. The bench therefore compares every walk entry and every peek against sequences computed from the pointer rule.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_STEP = 2'd1,
        WK_LAST = 2'd2
    } walk_state_e;

    localparam int CTRL_EN_BIT  = 31;
    localparam int CTRL_CH_LSB  = 16;
    localparam int HI_FIELD_LSB = 16;
endpackage

// File: rtl/cfp_ram.sv
module cfp_ram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cfp_ptr_next.sv
module cfp_ptr_next #(
    parameter int AW = 9
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (cur == hi_bound) begin
            nxt = lo_bound;
        end else begin
            nxt = cur + AW'(1);
        end
    end
endmodule

// File: rtl/cfp_peek_ctl.sv
module cfp_peek_ctl import cfp_pkg::*; #(
    parameter int DW   = 32,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [31:0]     wdata,
    input  logic            busy,
    input  logic [DW-1:0]   ram_rdata,
    output logic            ctrl_en,
    output logic [CH_W-1:0] ctrl_ch,
    output logic [DW-1:0]   peek_data
);
    logic          en_q;
    logic [CH_W-1:0] ch_q;
    logic [DW-1:0] peek_q;
    logic          accept;
    logic          unused_wbits;

    // A second enable without a clearing write in between is dropped.
    assign accept = wr && !busy && !(en_q && wdata[CTRL_EN_BIT]);
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ch_q   <= '0;
            peek_q <= '0;
        end else if (accept) begin
            en_q <= wdata[CTRL_EN_BIT];
            ch_q <= wdata[CTRL_CH_LSB +: CH_W];
            if (wdata[CTRL_EN_BIT]) begin
                peek_q <= ram_rdata;
            end
        end
    end

    assign ctrl_en   = en_q;
    assign ctrl_ch   = ch_q;
    assign peek_data = en_q ? peek_q : '0;
endmodule

// File: rtl/cfp_walk_fsm.sv
module cfp_walk_fsm import cfp_pkg::*; #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          en,
    input  logic          empty,
    input  logic [AW-1:0] rd_ptr,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_raddr,
    output logic          busy,
    output logic          walk_valid,
    output logic [AW-1:0] walk_addr,
    output logic [DW-1:0] walk_data,
    output logic          walk_done,
    output logic [AW-1:0] lo_snap,
    output logic [AW-1:0] hi_snap,
    output logic [AW-1:0] end_snap
);
    walk_state_e state_q, state_d;
    logic [AW-1:0] cur_q, cur_nxt;
    logic [AW-1:0] lo_q, hi_q, end_q;
    logic          start;
    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    assign start = go && en && !empty;

    cfp_ptr_next #(.AW(AW)) u_step (
        .cur      (cur_q),
        .lo_bound (lo_q),
        .hi_bound (hi_q),
        .nxt      (cur_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, advance, finish, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE: if (start) state_d = WK_STEP;
            WK_STEP: if (cur_nxt == end_q) state_d = WK_LAST;
            WK_LAST: state_d = WK_IDLE;
            default: state_d = WK_IDLE;
        endcase
    end

    // Outputs and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            end_q   <= '0;
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (state_q == WK_IDLE && start) begin
                cur_q <= rd_ptr;
                lo_q  <= lo_bound;
                hi_q  <= hi_bound;
                end_q <= wr_ptr;
            end else if (state_q == WK_STEP) begin
                cur_q <= cur_nxt;
            end
            valid_q <= (state_q == WK_STEP);
            if (state_q == WK_STEP) begin
                addr_q <= cur_q;
                data_q <= ram_rdata;
            end
        end
    end

    assign ram_raddr  = cur_q;
    assign busy       = (state_q != WK_IDLE);
    assign walk_valid = valid_q;
    assign walk_addr  = addr_q;
    assign walk_data  = data_q;
    assign walk_done  = (state_q == WK_LAST);
    assign lo_snap    = lo_q;
    assign hi_snap    = hi_q;
    assign end_snap   = end_q;
endmodule

// File: rtl/cfp_peek.sv
module cfp_peek import cfp_pkg::*; #(
    parameter int AW     = 9,
    parameter int DW     = 32,
    parameter int NUM_CH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ram_we,
    input  logic [AW-1:0]      ram_waddr,
    input  logic [DW-1:0]      ram_wdata,
    input  logic [NUM_CH*32-1:0] setup_words,
    input  logic [NUM_CH*AW-1:0] rd_ptrs,
    input  logic [NUM_CH*AW-1:0] wr_ptrs,
    input  logic               ctrl_wr,
    input  logic [31:0]        ctrl_wdata,
    input  logic               walk_go,
    output logic [DW-1:0]      peek_data,
    output logic [31:0]        ptr_word,
    output logic               cf_empty,
    output logic               walk_valid,
    output logic [AW-1:0]      walk_addr,
    output logic [DW-1:0]      walk_data,
    output logic               walk_done
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [AW-1:0] rd_arr [NUM_CH];
    logic [AW-1:0] wr_arr [NUM_CH];
    logic [AW-1:0] lo_arr [NUM_CH];
    logic [AW-1:0] hi_arr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign rd_arr[g] = rd_ptrs[g*AW +: AW];
        assign wr_arr[g] = wr_ptrs[g*AW +: AW];
        assign lo_arr[g] = setup_words[g*32 +: AW];
        assign hi_arr[g] = setup_words[g*32 + HI_FIELD_LSB +: AW];
    end

    logic          unused_setup;
    assign unused_setup = ^setup_words;

    logic            ctrl_en;
    logic [CH_W-1:0] ctrl_ch;
    logic            walk_busy;
    logic [DW-1:0]   rdata_a, rdata_b;
    logic [AW-1:0]   walk_raddr;
    logic [AW-1:0]   wk_lo, wk_hi, wk_end;
    logic [AW-1:0]   sel_rd, sel_wr;

    assign sel_rd   = rd_arr[ctrl_ch];
    assign sel_wr   = wr_arr[ctrl_ch];
    assign cf_empty = (sel_rd == sel_wr);

    always_comb begin
        ptr_word = '0;
        ptr_word[AW-1:0] = sel_rd;
        ptr_word[HI_FIELD_LSB +: AW] = sel_wr;
    end

    cfp_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (ctrl_wdata[AW-1:0]),
        .rdata_a (rdata_a),
        .raddr_b (walk_raddr),
        .rdata_b (rdata_b)
    );

    cfp_peek_ctl #(.DW(DW), .CH_W(CH_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctrl_wr),
        .wdata     (ctrl_wdata),
        .busy      (walk_busy),
        .ram_rdata (rdata_a),
        .ctrl_en   (ctrl_en),
        .ctrl_ch   (ctrl_ch),
        .peek_data (peek_data)
    );

    cfp_walk_fsm #(.AW(AW), .DW(DW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (walk_go),
        .en         (ctrl_en),
        .empty      (cf_empty),
        .rd_ptr     (sel_rd),
        .wr_ptr     (sel_wr),
        .lo_bound   (lo_arr[ctrl_ch]),
        .hi_bound   (hi_arr[ctrl_ch]),
        .ram_rdata  (rdata_b),
        .ram_raddr  (walk_raddr),
        .busy       (walk_busy),
        .walk_valid (walk_valid),
        .walk_addr  (walk_addr),
        .walk_data  (walk_data),
        .walk_done  (walk_done),
        .lo_snap    (wk_lo),
        .hi_snap    (wk_hi),
        .end_snap   (wk_end)
    );
endmodule

// File: rtl/cfp_peek_chk.sv
module cfp_peek_chk #(
    parameter int AW   = 9,
    parameter int DW   = 32,
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_wr,
    input logic [31:0]     ctrl_wdata,
    input logic            walk_go,
    input logic            cf_empty,
    input logic [DW-1:0]   peek_data,
    input logic            walk_valid,
    input logic [AW-1:0]   walk_addr,
    input logic            walk_done,
    input logic            walk_busy,
    input logic            ctrl_en,
    input logic [CH_W-1:0] ctrl_ch,
    input logic [AW-1:0]   wk_lo,
    input logic [AW-1:0]   wk_hi,
    input logic [AW-1:0]   wk_end
);
    assert_peek_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[31] && !walk_busy) |=> (peek_data == '0));

    assert_reenable_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[31] && ctrl_en && !walk_busy)
        |=> ($stable(peek_data) && $stable(ctrl_ch)));

    assert_walk_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_valid && $past(walk_valid)) |->
        (walk_addr == (($past(walk_addr) == wk_hi) ? wk_lo : AW'($past(walk_addr) + AW'(1)))));

    assert_walk_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid |-> (walk_addr != wk_end));

    assert_done_with_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> walk_valid);

    assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_valid);

    assert_no_start_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_go && !walk_busy && (cf_empty || !ctrl_en)) |=> !walk_busy);

    assert_ctrl_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && ctrl_wr) |=> ($stable(ctrl_en) && $stable(ctrl_ch)));
endmodule

bind cfp_peek cfp_peek_chk #(.AW(AW), .DW(DW), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .walk_go    (walk_go),
    .cf_empty   (cf_empty),
    .peek_data  (peek_data),
    .walk_valid (walk_valid),
    .walk_addr  (walk_addr),
    .walk_done  (walk_done),
    .walk_busy  (walk_busy),
    .ctrl_en    (ctrl_en),
    .ctrl_ch    (ctrl_ch),
    .wk_lo      (wk_lo),
    .wk_hi      (wk_hi),
    .wk_end     (wk_end)
);

// File: tb/cfp_peek_tb.sv
module cfp_peek_tb;
    localparam int AW  = 9;
    localparam int DW  = 32;
    localparam int NCH = 8;

    // {channel[2:0], address[8:0]}
    localparam logic [11:0] VEC [8] = '{
        {3'd0, 9'd5},   {3'd1, 9'd17},  {3'd2, 9'd0},   {3'd3, 9'd511},
        {3'd4, 9'd256}, {3'd5, 9'd100}, {3'd6, 9'd300}, {3'd7, 9'd42}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               ram_we;
    logic [AW-1:0]      ram_waddr;
    logic [DW-1:0]      ram_wdata;
    logic [NCH*32-1:0]  setup_words;
    logic [NCH*AW-1:0]  rd_ptrs, wr_ptrs;
    logic               ctrl_wr;
    logic [31:0]        ctrl_wdata;
    logic               walk_go;
    logic [DW-1:0]      peek_data;
    logic [31:0]        ptr_word;
    logic               cf_empty;
    logic               walk_valid;
    logic [AW-1:0]      walk_addr;
    logic [DW-1:0]      walk_data;
    logic               walk_done;

    logic [AW-1:0] b_rd [NCH];
    logic [AW-1:0] b_wr [NCH];
    logic [AW-1:0] b_lo [NCH];
    logic [AW-1:0] b_hi [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_pack
        assign rd_ptrs[g*AW +: AW]   = b_rd[g];
        assign wr_ptrs[g*AW +: AW]   = b_wr[g];
        assign setup_words[g*32 +: 32] = {7'd0, b_hi[g], 7'd0, b_lo[g]};
    end

    cfp_peek #(.AW(AW), .DW(DW), .NUM_CH(NCH)) u_dut (.*);

    int n_chk  = 0;
    int n_fail = 0;

    function automatic logic [31:0] pat(input int a);
        return 32'hA500_0000 ^ (32'(a) << 12) ^ (32'(a) * 7);
    endfunction

    function automatic logic [31:0] cw(input bit en, input int ch, input int a);
        return {en, 12'd0, 3'(ch), 7'd0, 9'(a)};
    endfunction

    function automatic logic [31:0] pw(input int ch);
        return {7'd0, b_wr[ch], 7'd0, b_rd[ch]};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_wr = 1'b0;
        ctrl_wdata = '0;
    endtask

    task automatic walk_chk(input int ch, input int exp_n, input bit poke, input string rq);
        logic [AW-1:0] p;
        int got;
        p = b_rd[ch];
        got = 0;
        @(negedge clk);
        walk_go = 1'b1;
        @(negedge clk);
        walk_go = 1'b0;
        if (poke) begin
            ctrl_wr = 1'b1;
            ctrl_wdata = '0;
        end
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i == 0) ctrl_wr = 1'b0;
            if (walk_valid) begin
                chk(walk_addr === p, "R8 R9 walk address", 32'(walk_addr), 32'(p));
                chk(walk_data === pat(int'(p)), "R8 walk data", walk_data, pat(int'(p)));
                chk(walk_done === (got == exp_n - 1), "R10 done on last", 32'(walk_done), 32'(got == exp_n - 1));
                got++;
                p = (p == b_hi[ch]) ? b_lo[ch] : p + 1'b1;
            end else begin
                chk(walk_done === 1'b0, "R10 done without entry", 32'(walk_done), 32'd0);
            end
        end
        chk(got == exp_n, rq, 32'(got), 32'(exp_n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ram_we = 1'b0;
        ram_waddr = '0;
        ram_wdata = '0;
        ctrl_wr = 1'b0;
        ctrl_wdata = '0;
        walk_go = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            b_lo[c] = 9'(c * 20);
            b_hi[c] = 9'(c * 20 + 15);
            b_rd[c] = 9'(c * 20 + 3);
            b_wr[c] = 9'(c * 20 + ((c % 2 == 1) ? 3 : 9));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(peek_data === '0, "R1 peek after reset", peek_data, 32'd0);
        chk(walk_valid === 1'b0, "R1 walk_valid after reset", 32'(walk_valid), 32'd0);
        chk(walk_done === 1'b0, "R1 walk_done after reset", 32'(walk_done), 32'd0);
        chk(ptr_word === pw(0), "R1 R5 ptr word channel 0", ptr_word, pw(0));

        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            ram_we = 1'b1;
            ram_waddr = 9'(a);
            ram_wdata = pat(a);
        end
        @(negedge clk);
        ram_we = 1'b0;

        // Vector table: peek, pointer word (R6 bounds packed by bench), empty flag, disable
        for (int v = 0; v < 8; v++) begin
            int ch;
            int ad;
            ch = int'(VEC[v][11:9]);
            ad = int'(VEC[v][8:0]);
            wr_ctrl(cw(1'b1, ch, ad));
            chk(peek_data === pat(ad), "R2 peek data", peek_data, pat(ad));
            chk(ptr_word === pw(ch), "R5 pointer word", ptr_word, pw(ch));
            chk(cf_empty === (b_rd[ch] == b_wr[ch]), "R7 empty flag", 32'(cf_empty), 32'(b_rd[ch] == b_wr[ch]));
            @(negedge clk);
            chk(peek_data === pat(ad), "R2 peek holds", peek_data, pat(ad));
            wr_ctrl(32'd0);
            chk(peek_data === '0, "R3 disabled peek reads zero", peek_data, 32'd0);
        end

        // R4 second enable without clearing is ignored
        wr_ctrl(cw(1'b1, 1, 10));
        wr_ctrl(cw(1'b1, 4, 20));
        chk(peek_data === pat(10), "R4 re-enable ignored data", peek_data, pat(10));
        chk(ptr_word === pw(1), "R4 re-enable ignored channel", ptr_word, pw(1));
        wr_ctrl(32'd0);

        // R9 wrapping walk on channel 2, R12 control write during walk
        b_lo[2] = 9'd100;
        b_hi[2] = 9'd107;
        b_rd[2] = 9'd105;
        b_wr[2] = 9'd102;
        wr_ctrl(cw(1'b1, 2, 0));
        walk_chk(2, 5, 1'b1, "R9 wrapped walk length");
        chk(peek_data === pat(0), "R12 control write during walk ignored", peek_data, pat(0));

        // R10 single-entry walk ending at the wrap point
        wr_ctrl(32'd0);
        b_lo[5] = 9'd200;
        b_hi[5] = 9'd210;
        b_rd[5] = 9'd210;
        b_wr[5] = 9'd200;
        wr_ctrl(cw(1'b1, 5, 0));
        walk_chk(5, 1, 1'b0, "R10 single entry walk");

        // R11 empty channel: no walk
        wr_ctrl(32'd0);
        wr_ctrl(cw(1'b1, 3, 0));
        chk(cf_empty === 1'b1, "R7 empty channel 3", 32'(cf_empty), 32'd1);
        walk_chk(3, 0, 1'b0, "R11 no walk when empty");

        // R11 disabled: no walk on non-empty channel 0
        wr_ctrl(32'd0);
        chk(cf_empty === 1'b0, "R7 channel 0 not empty", 32'(cf_empty), 32'd0);
        walk_chk(0, 0, 1'b0, "R11 no walk when disabled");

        // R8 plain walk on channel 0 without wrap
        wr_ctrl(cw(1'b1, 0, 0));
        walk_chk(0, 6, 1'b0, "R8 walk length channel 0");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule